// File: doc/BRIEF.md
# Priority Interrupt Acceptance Logic

This block sits between an interrupt delivery fabric and a processor core. Each incoming request carries an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary requests are queued in a 256-entry request array, with a parallel array that records the trigger type of each vector. Four special request types go into their own single-entry pending slots instead. Those types are system-management, non-maskable, initialisation and external-controller.

Each cycle the block picks one interrupt to present to the core. A fixed precedence picks among the special slots. Ordinary vectors are gated by two things: the current in-service level, and a 4-bit priority class taken from the task priority input. The core takes an interrupt with a one-cycle acknowledge strobe. On acknowledge, an ordinary vector moves from the request array to the in-service array, while a special type simply clears its slot. An end-of-interrupt pulse retires the highest in-service vector.

Top module: `irq_accept`

## Requirements
- R1: After reset nothing is pending: irq_pending_o is 0 and irq_vector_o, irq_kind_o and irq_level_o are all zero.
- R2: A request with mode 0 (fixed) or mode 1 (lowest priority) sets the vector's request bit. The vector's trigger bit is written (1 = level, 0 = edge) only if the request bit was clear before. irq_level_o shows the trigger bit of the presented ordinary vector.
- R3: The special modes each latch their vector into their own slot: mode 2 (system management), mode 4 (non-maskable), mode 5 (initialisation) and mode 7 (external). A request whose slot is already pending is dropped and the first vector is kept. Modes 3 and 6 are reserved and dropped.
- R4: The system-management, non-maskable and initialisation slots are presented whatever int_enable_i is. The external slot and ordinary vectors are presented only while int_enable_i is 1.
- R5: An ordinary vector is presented only if both hold. First, the highest requested vector must be greater than the highest in-service vector. Second, its bits 7:4 must be greater than task_prio_i bits 7:4. An empty array counts as a highest vector of zero.
- R6: Presentation precedence, with irq_kind_o codes: system management (1), non-maskable (2), initialisation (3), external (4), then the highest ordinary vector (0).
- R7: Acknowledging an ordinary vector sets its in-service bit and clears its request bit.
- R8: Acknowledging a special type clears only that type's slot.
- R9: eoi_i clears the in-service bit of the highest in-service vector.
- R10: ack_i has no effect while irq_pending_o is 0.
- R11: While irq_pending_o is 0, irq_vector_o, irq_kind_o and irq_level_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Request vector |
| req_mode_i | input | 3 | Request delivery mode |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge |
| int_enable_i | input | 1 | Core maskable-interrupt enable |
| task_prio_i | input | 8 | Task priority; bits 7:4 are compared |
| ack_i | input | 1 | One-cycle acknowledge of the presented interrupt |
| eoi_i | input | 1 | End-of-interrupt pulse |
| irq_pending_o | output | 1 | An interrupt is presented |
| irq_vector_o | output | 8 | Presented vector |
| irq_kind_o | output | 3 | Presented type code |
| irq_level_o | output | 1 | Trigger bit of the presented ordinary vector |

## Verification
The hardest situation to reach from the ports is a stack of nested in-service vectors together with a task priority sitting exactly at a request's class boundary. In that state the presentation decision turns on strict comparisons against two separate references. Directed sequences build this up on purpose: they acknowledge a high vector, queue a lower one behind it, retire the higher one with an end-of-interrupt, and step the task priority across the class edge. A long seeded random phase then mixes acknowledges, end-of-interrupt pulses and colliding special requests. A bench model predicts every output each cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [2:0] {
    KIND_REG  = 3'd0,
    KIND_SMI  = 3'd1,
    KIND_NMI  = 3'd2,
    KIND_INIT = 3'd3,
    KIND_EXT  = 3'd4
  } irq_kind_e;

  localparam int          NUM_SLOT    = 4;
  localparam logic [2:0]  MODE_FIXED  = 3'd0;
  localparam logic [2:0]  MODE_LOWEST = 3'd1;

  // slot index -> delivery mode code (index order is precedence)
  function automatic logic [2:0] slot_mode(int s);
    case (s)
      0:       return 3'd2;
      1:       return 3'd4;
      2:       return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic irq_kind_e slot_kind(int s);
    case (s)
      0:       return KIND_SMI;
      1:       return KIND_NMI;
      2:       return KIND_INIT;
      default: return KIND_EXT;
    endcase
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  in_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_special_slot.sv
module irq_special_slot #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      vec_o  <= '0;
    end else if (set_i && !pend_o) begin
      pend_o <= 1'b1;
      vec_o  <= vec_i;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [VEC_W-1:0] set_vec_i,
  input  logic             set_level_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic [VEC_W-1:0] req_hi_o,
  output logic [VEC_W-1:0] isr_hi_o,
  output logic             hi_level_o
);
  logic [NUM_VEC-1:0] req_q, isr_q, trig_q;
  logic [NUM_VEC-1:0] req_d, isr_d, trig_d;
  logic [NUM_VEC-1:0] set_oh, ack_oh, eoi_oh;

  irq_prio_enc #(.W(NUM_VEC), .IW(VEC_W)) u_req_enc (.in_i(req_q), .idx_o(req_hi_o));
  irq_prio_enc #(.W(NUM_VEC), .IW(VEC_W)) u_isr_enc (.in_i(isr_q), .idx_o(isr_hi_o));

  assign set_oh     = set_i ? (NUM_VEC'(1) << set_vec_i) : '0;
  assign ack_oh     = ack_i ? (NUM_VEC'(1) << req_hi_o)  : '0;
  assign eoi_oh     = eoi_i ? (NUM_VEC'(1) << isr_hi_o)  : '0;
  assign hi_level_o = trig_q[req_hi_o];

  always_comb begin
    req_d  = (req_q & ~ack_oh) | set_oh;
    isr_d  = (isr_q & ~eoi_oh) | ack_oh;
    trig_d = trig_q;
    // trigger type captured only on a fresh request
    if (set_i && !req_q[set_vec_i]) trig_d[set_vec_i] = set_level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      isr_q  <= '0;
      trig_q <= '0;
    end else begin
      req_q  <= req_d;
      isr_q  <= isr_d;
      trig_q <= trig_d;
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = $clog2(NUM_VEC),
  parameter int CLASS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vector_i,
  input  logic [2:0]       req_mode_i,
  input  logic             req_level_i,
  input  logic             int_enable_i,
  input  logic [VEC_W-1:0] task_prio_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_pending_o,
  output logic [VEC_W-1:0] irq_vector_o,
  output logic [2:0]       irq_kind_o,
  output logic             irq_level_o
);
  localparam int CLS_LSB = VEC_W - CLASS_W;

  logic [NUM_SLOT-1:0] slot_pend, slot_set, slot_clr;
  logic [VEC_W-1:0]    slot_vec [NUM_SLOT];
  logic [VEC_W-1:0]    req_hi, isr_hi;
  logic                hi_level, reg_set, reg_ok, unmask_pend, ack_ok;
  logic [NUM_SLOT-1:0] sel_slot;
  logic                sel_reg;

  assign reg_set = req_valid_i && (req_mode_i == MODE_FIXED || req_mode_i == MODE_LOWEST);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    assign slot_set[s] = req_valid_i && (req_mode_i == slot_mode(s));
    assign slot_clr[s] = ack_ok && sel_slot[s];
    irq_special_slot #(.VEC_W(VEC_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (slot_set[s]),
      .vec_i  (req_vector_i),
      .clr_i  (slot_clr[s]),
      .pend_o (slot_pend[s]),
      .vec_o  (slot_vec[s])
    );
  end

  irq_vec_store #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (reg_set),
    .set_vec_i   (req_vector_i),
    .set_level_i (req_level_i),
    .ack_i       (ack_ok && sel_reg),
    .eoi_i       (eoi_i),
    .req_hi_o    (req_hi),
    .isr_hi_o    (isr_hi),
    .hi_level_o  (hi_level)
  );

  assign unmask_pend = |slot_pend[NUM_SLOT-2:0];
  assign reg_ok      = (req_hi > isr_hi) &&
                       (req_hi[VEC_W-1:CLS_LSB] > task_prio_i[VEC_W-1:CLS_LSB]);

  always_comb begin
    sel_slot = '0;
    sel_reg  = 1'b0;
    if (unmask_pend) begin
      if      (slot_pend[0]) sel_slot[0] = 1'b1;
      else if (slot_pend[1]) sel_slot[1] = 1'b1;
      else                   sel_slot[2] = 1'b1;
    end else if (int_enable_i) begin
      if (slot_pend[NUM_SLOT-1]) sel_slot[NUM_SLOT-1] = 1'b1;
      else if (reg_ok)           sel_reg = 1'b1;
    end
  end

  assign irq_pending_o = sel_reg || (|sel_slot);
  assign ack_ok        = ack_i && irq_pending_o;

  always_comb begin
    irq_vector_o = '0;
    irq_kind_o   = 3'd0;
    irq_level_o  = 1'b0;
    if (sel_reg) begin
      irq_vector_o = req_hi;
      irq_kind_o   = KIND_REG;
      irq_level_o  = hi_level;
    end
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (sel_slot[s]) begin
        irq_vector_o = slot_vec[s];
        irq_kind_o   = slot_kind(s);
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_accept_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [2:0]       req_mode_i,
  input logic             int_enable_i,
  input logic [VEC_W-1:0] task_prio_i,
  input logic             ack_i,
  input logic             irq_pending_o,
  input logic [VEC_W-1:0] irq_vector_o,
  input logic [2:0]       irq_kind_o
);
  AST_MASKED_ONLY_UNMASKABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pending_o && !int_enable_i) |-> (irq_kind_o inside {KIND_SMI, KIND_NMI, KIND_INIT})); // R4

  AST_REG_ABOVE_TPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pending_o && irq_kind_o == KIND_REG) |-> (irq_vector_o[VEC_W-1:VEC_W-4] > task_prio_i[VEC_W-1:VEC_W-4])); // R5

  AST_SMI_TAKES_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mode_i == 3'd2 && !(ack_i && irq_pending_o && irq_kind_o == KIND_SMI))
      |=> (irq_pending_o && irq_kind_o == KIND_SMI)); // R6

  AST_ACK_RAISES_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_pending_o && irq_kind_o == KIND_REG)
      |=> (!(irq_pending_o && irq_kind_o == KIND_REG) || irq_vector_o > $past(irq_vector_o))); // R7

  AST_NMI_PERSISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pending_o && irq_kind_o == KIND_NMI && !ack_i)
      |=> (irq_pending_o && irq_kind_o inside {KIND_SMI, KIND_NMI})); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_pending_o |-> (irq_vector_o == '0 && irq_kind_o == 3'd0)); // R11
endmodule

bind irq_accept irq_accept_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_mode_i    (req_mode_i),
  .int_enable_i  (int_enable_i),
  .task_prio_i   (task_prio_i),
  .ack_i         (ack_i),
  .irq_pending_o (irq_pending_o),
  .irq_vector_o  (irq_vector_o),
  .irq_kind_o    (irq_kind_o)
);

// File: tb/irq_accept_test.sv
`timescale 1ns/1ps
module irq_accept_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_vector = '0;
  logic [2:0] req_mode = '0;
  logic       req_level = 1'b0;
  logic       int_en = 1'b0;
  logic [7:0] tpr = '0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       pend;
  logic [7:0] vec;
  logic [2:0] kind;
  logic       lvl;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // model state
  bit [255:0] m_req, m_isr, m_trig;
  bit [3:0]   m_flag;
  bit [7:0]   m_svec [4];

  always #2 clk = ~clk;

  irq_accept uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vector_i(req_vector),
    .req_mode_i(req_mode), .req_level_i(req_level), .int_enable_i(int_en),
    .task_prio_i(tpr), .ack_i(ack), .eoi_i(eoi), .irq_pending_o(pend),
    .irq_vector_o(vec), .irq_kind_o(kind), .irq_level_o(lvl)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete (cycle %0d, expected < 150000)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int hi(bit [255:0] a);
    int r = 0;
    for (int i = 0; i < 256; i++) if (a[i]) r = i;
    return r;
  endfunction

  function automatic int slot_of(bit [2:0] m);
    case (m)
      3'd2: return 0;
      3'd4: return 1;
      3'd5: return 2;
      3'd7: return 3;
      default: return -1;
    endcase
  endfunction

  // expected outputs from model + current inputs
  function automatic void expect_out(output bit p, output bit [7:0] v, output bit [2:0] k,
                                     output bit l, output int sel);
    int rh = hi(m_req), ih = hi(m_isr);
    p = 0; v = 0; k = 0; l = 0; sel = -1;
    if (m_flag[0]) begin p = 1; sel = 0; end
    else if (m_flag[1]) begin p = 1; sel = 1; end
    else if (m_flag[2]) begin p = 1; sel = 2; end
    else if (int_en && m_flag[3]) begin p = 1; sel = 3; end
    else if (int_en && rh > ih && rh[7:4] > int'(tpr[7:4])) begin
      p = 1; sel = 4; v = 8'(rh); l = m_trig[rh];
    end
    if (sel >= 0 && sel < 4) begin v = m_svec[sel]; k = 3'(sel + 1); end
  endfunction

  task automatic check_outs(string tag);
    bit ep, el; bit [7:0] ev; bit [2:0] ek; int sel;
    expect_out(ep, ev, ek, el, sel);
    n_tests++;
    if (pend !== ep || vec !== ev || kind !== ek || lvl !== el) begin
      n_fail++;
      $display("FAIL %s: pend/vec/kind/lvl got %0b/%02h/%0d/%0b expected %0b/%02h/%0d/%0b",
               tag, pend, vec, kind, lvl, ep, ev, ek, el);
    end
  endtask

  // one cycle: drive at negedge, check, advance model; want_ack 2 forces ack
  task automatic step(bit v, bit [7:0] vv, bit [2:0] md, bit lv, bit en, bit [7:0] tp,
                      int want_ack, bit e, string tag);
    bit ep, el; bit [7:0] ev; bit [2:0] ek; int sel, ih, s;
    @(negedge clk);
    req_valid = v; req_vector = vv; req_mode = md; req_level = lv;
    int_en = en; tpr = tp; eoi = e;
    expect_out(ep, ev, ek, el, sel);
    ack = (want_ack == 2) || (want_ack == 1 && ep);
    #1;
    check_outs(tag);
    ih = hi(m_isr);
    if (ack && ep) begin
      if (sel == 4) m_req[ev] = 0;
      else m_flag[sel] = 0;
    end
    if (e) m_isr[ih] = 0;
    if (ack && ep && sel == 4) m_isr[ev] = 1;
    if (v) begin
      if (md == 3'd0 || md == 3'd1) begin
        if (!m_req[vv] || (ack && ep && sel == 4 && ev == vv)) begin
          // trigger written only when the bit was clear before this cycle
          if (!(ack && ep && sel == 4 && ev == vv)) m_trig[vv] = lv;
        end
        m_req[vv] = 1;
      end else begin
        s = slot_of(md);
        if (s >= 0 && !(m_flag[s] || (ack && ep && sel == s))) begin
          m_flag[s] = 1; m_svec[s] = vv;
        end
      end
    end
  endtask

  task automatic idle(bit en, bit [7:0] tp, string tag);
    step(0, 0, 0, 0, en, tp, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_req = '0; m_isr = '0; m_trig = '0; m_flag = '0;
    for (int i = 0; i < 4; i++) m_svec[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (pend !== 0 || vec !== 0 || kind !== 0 || lvl !== 0) begin
      n_fail++;
      $display("FAIL R1: in reset got %0b/%02h/%0d/%0b expected 0/00/0/0", pend, vec, kind, lvl);
    end
    rst_n = 1'b1;
    idle(1, 0, "R1");

    // R2: level request, re-request as edge keeps trigger bit
    step(1, 8'h45, 3'd0, 1, 1, 0, 0, 0, "R2");
    step(1, 8'h45, 3'd1, 0, 1, 0, 0, 0, "R2");
    idle(1, 0, "R2");
    // R7: ack moves to in-service; lower request then waits
    step(0, 0, 0, 0, 1, 0, 1, 0, "R7");
    step(1, 8'h30, 3'd1, 0, 1, 0, 0, 0, "R5");
    idle(1, 0, "R5");
    // R9: eoi retires 0x45, 0x30 appears
    step(0, 0, 0, 0, 1, 0, 0, 1, "R9");
    idle(1, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, 1, "R9");
    idle(1, 0, "R11");
    // R5: class boundary on task priority
    step(1, 8'h52, 3'd0, 0, 1, 8'h50, 0, 0, "R5");
    idle(1, 8'h50, "R5");
    idle(1, 8'h4f, "R5");
    idle(0, 8'h00, "R4");
    step(0, 0, 0, 0, 1, 8'h4f, 1, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, 1, "R9");
    // R10: ack with nothing pending
    step(0, 0, 0, 0, 1, 0, 2, 0, "R10");
    idle(1, 0, "R10");
    // R3/R4: NMI while masked, duplicate dropped, reserved modes dropped
    step(1, 8'h02, 3'd4, 0, 0, 0, 0, 0, "R4");
    step(1, 8'h09, 3'd4, 0, 0, 0, 0, 0, "R3");
    step(1, 8'h77, 3'd3, 0, 0, 0, 0, 0, "R3");
    step(1, 8'h78, 3'd6, 1, 0, 0, 0, 0, "R3");
    step(1, 8'h20, 3'd7, 0, 0, 0, 0, 0, "R4");
    idle(0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R8");
    idle(0, 0, "R4");
    idle(1, 0, "R4");
    // R6: precedence INIT < SMI, then external, then nothing
    step(1, 8'h11, 3'd5, 0, 1, 0, 0, 0, "R6");
    step(1, 8'h22, 3'd2, 0, 1, 0, 0, 0, "R6");
    idle(1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R6");
    idle(1, 0, "R11");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [2:0] md;
      int wa;
      md = ($urandom_range(0, 3) != 0) ? 3'($urandom_range(0, 1)) : 3'($urandom_range(0, 7));
      wa = ($urandom_range(0, 99) < 40) ? 1 : (($urandom_range(0, 99) < 5) ? 2 : 0);
      step($urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)), md, $urandom_range(0, 1) == 1,
           $urandom_range(0, 9) < 8, 8'($urandom_range(0, 127)), wa,
           $urandom_range(0, 9) == 0, "R6");
    end
    idle(1, 0, "R6");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule